// File: doc/BRIEF.md
# Branch Hint Buffer

This unit serves an in-order pipeline that keeps no branch history of its own. All of its predictions come from hint instructions placed by software. A hint names two things: the address of a future instruction, which is the trigger, and the address where control should go when that instruction is reached. The unit holds exactly one such pair. It compares every instruction address that enters issue against the trigger. On a hit it predicts a taken transfer to the stored target. In every other case it predicts the next sequential word.

A hint takes time to become useful. If the trigger is reached too soon after its hint, the unit handles it in one of two ways:

- It holds the trigger instruction at issue until the required lead has passed.
- If the trigger is reached very early, it drops the hint without any stall.

A second port reports resolved control transfers. When the real next address differs from the predicted one, the unit raises a flush carrying the correct refetch address.

Top module: `branch_hint_buffer`

## Requirements
- R1: After synchronous reset no hint is held, and `pred_valid`, `flush_valid` and `hint_stall` are low. An instruction issued right after reset is predicted not taken, with `pred_pc` equal to its address plus 4.
- R2: The trigger address is `hint_pc` plus 4 times the sign-extended 11-bit `hint_trig_off`, taken modulo 2^32.
- R3: The target depends on the `hint_form` code. Code 0 (register) gives `hint_reg_word` with bits [1:0] cleared. Code 1 (absolute) gives 4 times the sign-extended 18-bit `hint_tgt_imm`. Code 2 (relative) gives `hint_pc` plus 4 times that same value. Code 3 loads nothing and leaves the held entry unchanged.
- R4: A hint whose `hint_trig_off` lies outside -255..255 loads nothing, and the previously held entry keeps firing.
- R5: An accepted hint replaces the held one from the next cycle on, so the old trigger no longer fires.
- R6: Let the distance d be the number of cycles from the hint cycle to the issue cycle. A matching issue with d >= 15 fires: in the next cycle `pred_valid`=1, `pred_taken`=1 and `pred_pc` equals the target.
- R7: An issue that does not fire and is not stalled is predicted not taken in the next cycle, with `pred_pc` equal to the issue address plus 4.
- R8: A matching issue with 5 <= d <= 14 raises `hint_stall` in that same cycle. No prediction is produced while the stall lasts. With the issue held, the stall lasts exactly 15-d cycles and then the hint fires.
- R9: A matching issue with d <= 4 raises no stall and is predicted not taken. The hint is discarded, so later matches also fall through.
- R10: Firing does not consume the entry. The same trigger fires again on every later issue until a new hint is accepted.
- R11: In the cycle after a resolve, `flush_valid` is 1 when the actual next address differs from `res_pred_pc`, and `flush_pc` then carries that actual address. The actual address is `res_target` if `res_taken` is 1, and `res_pc`+4 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hint_valid | input | 1 | A hint instruction is presented this cycle |
| hint_pc | input | 32 | Byte address of the hint instruction |
| hint_form | input | 2 | Target form: 0 register, 1 absolute, 2 relative, 3 reserved |
| hint_trig_off | input | 11 | Signed trigger offset in instructions |
| hint_tgt_imm | input | 18 | Signed target immediate in instructions |
| hint_reg_word | input | 32 | Word 0 of the register operand |
| iss_valid | input | 1 | An instruction is at issue |
| iss_pc | input | 32 | Address of the instruction at issue |
| hint_stall | output | 1 | Hold the instruction at issue (same cycle) |
| pred_valid | output | 1 | Prediction for last cycle's issue is valid |
| pred_taken | output | 1 | Prediction is a hinted taken transfer |
| pred_pc | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A control transfer resolved this cycle |
| res_pc | input | 32 | Address of the resolved instruction |
| res_taken | input | 1 | Resolved instruction transferred control |
| res_target | input | 32 | Resolved transfer address |
| res_pred_pc | input | 32 | Next address that was predicted for it |
| flush_valid | output | 1 | Wrong path must be flushed |
| flush_pc | output | 32 | Correct refetch address |

## Verification
`hint_stall` is combinational: it answers in the same cycle the issue address is presented. The bench drives each input just after a falling edge and reads the stall one nanosecond later. A prediction or a flush shows up one edge after the issue or resolve that caused it, so those are read after the next falling edge. A loaded hint is in effect from the cycle after the hint. The distance sweep therefore places the trigger issue at d = 1 to 20 by inserting d-1 idle cycles after the load, and it counts the stall cycles against 15-d.

// File: rtl/bhb_pkg.sv
package bhb_pkg;
    parameter int ADDR_W   = 32;
    parameter int OFF_W    = 11;
    parameter int IMM_W    = 18;
    parameter int LEAD_CYC = 11;
    parameter int PAIR_CNT = 4;
    parameter int REACH    = 255;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        TGT_REG = 2'd0,
        TGT_ABS = 2'd1,
        TGT_REL = 2'd2,
        TGT_RSV = 2'd3
    } tgt_form_e;

    typedef enum logic [2:0] {
        V_IDLE  = 3'd0,
        V_PASS  = 3'd1,
        V_STALL = 3'd2,
        V_DROP  = 3'd3,
        V_FIRE  = 3'd4
    } verdict_e;

    typedef struct packed {
        logic  valid;
        addr_t trig;
        addr_t tgt;
    } hint_ent_t;

    // instruction count -> byte displacement, sign preserved
    function automatic addr_t scale_off(logic signed [IMM_W-1:0] v);
        logic signed [ADDR_W-1:0] w;
        w = ADDR_W'(v);
        return addr_t'(w <<< 2);
    endfunction

    function automatic logic in_reach(logic signed [OFF_W-1:0] o, int lim);
        return (int'(o) <= lim) && (int'(o) >= -lim);
    endfunction
endpackage

// File: rtl/bhb_addr_calc.sv
module bhb_addr_calc import bhb_pkg::*; #(
    parameter int REACH_LIM = REACH
) (
    input  logic                    hint_valid,
    input  addr_t                   hint_pc,
    input  tgt_form_e               form,
    input  logic signed [OFF_W-1:0] trig_off,
    input  logic signed [IMM_W-1:0] tgt_imm,
    input  addr_t                   reg_word,
    output hint_ent_t               cand,
    output logic                    accept
);
    logic form_ok;

    always_comb begin
        cand.valid = 1'b1;
        cand.trig  = hint_pc + scale_off(IMM_W'(trig_off));
        form_ok    = 1'b1;
        unique case (form)
            TGT_REG: cand.tgt = reg_word & ~addr_t'(3);
            TGT_ABS: cand.tgt = scale_off(tgt_imm);
            TGT_REL: cand.tgt = hint_pc + scale_off(tgt_imm);
            default: begin
                cand.tgt = '0;
                form_ok  = 1'b0;
            end
        endcase
        accept = hint_valid && form_ok && in_reach(trig_off, REACH_LIM);
    end
endmodule

// File: rtl/bhb_entry.sv
module bhb_entry import bhb_pkg::*; #(
    parameter int LEAD_TOTAL = LEAD_CYC + PAIR_CNT,
    parameter int AGE_W      = $clog2(LEAD_TOTAL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  hint_ent_t        cand,
    input  logic             drop,
    output hint_ent_t        ent_q,
    output logic [AGE_W-1:0] age_q
);
    localparam logic [AGE_W-1:0] AGE_FULL = AGE_W'(LEAD_TOTAL - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
            age_q <= '0;
        end else if (load) begin
            ent_q <= cand;
            age_q <= AGE_FULL;
        end else begin
            if (drop) ent_q.valid <= 1'b0;
            if (age_q != '0) age_q <= age_q - 1'b1;
        end
    end

    // R1
    rst_clears_chk: assert property (@(posedge clk) rst |=> !ent_q.valid);

    // R8
    age_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && age_q != '0) |=> (age_q == $past(age_q) - 1'b1));

    // R5
    load_takes_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (ent_q.valid && ent_q.trig == $past(cand.trig)
                  && ent_q.tgt == $past(cand.tgt) && age_q == AGE_FULL));
endmodule

// File: rtl/bhb_issue_ctl.sv
module bhb_issue_ctl import bhb_pkg::*; #(
    parameter int LEAD_TOTAL = LEAD_CYC + PAIR_CNT,
    parameter int DROP_WIN   = PAIR_CNT + 1,
    parameter int AGE_W      = $clog2(LEAD_TOTAL)
) (
    input  logic             iss_valid,
    input  addr_t            iss_pc,
    input  hint_ent_t        ent,
    input  logic [AGE_W-1:0] age,
    output verdict_e         verdict,
    output logic             stall,
    output logic             drop,
    output logic             fire
);
    // ages above this mean the trigger came inside the drop window
    localparam logic [AGE_W-1:0] DROP_ABOVE = AGE_W'(LEAD_TOTAL - DROP_WIN);

    logic hit;

    always_comb begin
        hit = iss_valid && ent.valid && (iss_pc == ent.trig);
        if (!iss_valid)              verdict = V_IDLE;
        else if (!hit)               verdict = V_PASS;
        else if (age > DROP_ABOVE)   verdict = V_DROP;
        else if (age != '0)          verdict = V_STALL;
        else                         verdict = V_FIRE;
        stall = (verdict == V_STALL);
        drop  = (verdict == V_DROP);
        fire  = (verdict == V_FIRE);
    end
endmodule

// File: rtl/bhb_flush.sv
module bhb_flush import bhb_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  res_valid,
    input  addr_t res_pc,
    input  logic  res_taken,
    input  addr_t res_target,
    input  addr_t res_pred_pc,
    output logic  flush_valid,
    output addr_t flush_pc
);
    addr_t actual_next;
    logic  miss;

    always_comb begin
        actual_next = res_taken ? res_target : (res_pc + addr_t'(4));
        miss        = res_valid && (actual_next != res_pred_pc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_valid <= 1'b0;
            flush_pc    <= '0;
        end else begin
            flush_valid <= miss;
            flush_pc    <= actual_next;
        end
    end

    // R11
    good_pred_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_taken && res_target == res_pred_pc) |=> !flush_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> !flush_valid);
endmodule

// File: rtl/branch_hint_buffer.sv
module branch_hint_buffer import bhb_pkg::*; #(
    parameter int LEAD_CYCLES = LEAD_CYC,
    parameter int PAIRS       = PAIR_CNT,
    parameter int REACH_LIM   = REACH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hint_valid,
    input  logic [ADDR_W-1:0]       hint_pc,
    input  logic [1:0]              hint_form,
    input  logic signed [OFF_W-1:0] hint_trig_off,
    input  logic signed [IMM_W-1:0] hint_tgt_imm,
    input  logic [ADDR_W-1:0]       hint_reg_word,
    input  logic                    iss_valid,
    input  logic [ADDR_W-1:0]       iss_pc,
    output logic                    hint_stall,
    output logic                    pred_valid,
    output logic                    pred_taken,
    output logic [ADDR_W-1:0]       pred_pc,
    input  logic                    res_valid,
    input  logic [ADDR_W-1:0]       res_pc,
    input  logic                    res_taken,
    input  logic [ADDR_W-1:0]       res_target,
    input  logic [ADDR_W-1:0]       res_pred_pc,
    output logic                    flush_valid,
    output logic [ADDR_W-1:0]       flush_pc
);
    localparam int LEAD_TOTAL = LEAD_CYCLES + PAIRS;
    localparam int DROP_WIN   = PAIRS + 1;
    localparam int AGE_W      = $clog2(LEAD_TOTAL);

    hint_ent_t        cand, ent;
    logic             accept;
    logic [AGE_W-1:0] age;
    verdict_e         verdict;
    logic             stall, drop, fire;

    bhb_addr_calc #(.REACH_LIM(REACH_LIM)) u_calc (
        .hint_valid (hint_valid),
        .hint_pc    (hint_pc),
        .form       (tgt_form_e'(hint_form)),
        .trig_off   (hint_trig_off),
        .tgt_imm    (hint_tgt_imm),
        .reg_word   (hint_reg_word),
        .cand       (cand),
        .accept     (accept)
    );

    bhb_entry #(.LEAD_TOTAL(LEAD_TOTAL), .AGE_W(AGE_W)) u_entry (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .cand  (cand),
        .drop  (drop),
        .ent_q (ent),
        .age_q (age)
    );

    bhb_issue_ctl #(.LEAD_TOTAL(LEAD_TOTAL), .DROP_WIN(DROP_WIN), .AGE_W(AGE_W)) u_issue (
        .iss_valid (iss_valid),
        .iss_pc    (iss_pc),
        .ent       (ent),
        .age       (age),
        .verdict   (verdict),
        .stall     (stall),
        .drop      (drop),
        .fire      (fire)
    );

    bhb_flush u_flush (
        .clk         (clk),
        .rst         (rst),
        .res_valid   (res_valid),
        .res_pc      (res_pc),
        .res_taken   (res_taken),
        .res_target  (res_target),
        .res_pred_pc (res_pred_pc),
        .flush_valid (flush_valid),
        .flush_pc    (flush_pc)
    );

    assign hint_stall = stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_valid <= 1'b0;
            pred_taken <= 1'b0;
            pred_pc    <= '0;
        end else begin
            pred_valid <= (verdict == V_PASS) || (verdict == V_DROP) || (verdict == V_FIRE);
            pred_taken <= fire;
            pred_pc    <= fire ? ent.tgt : (iss_pc + addr_t'(4));
        end
    end

    // R6
    fire_pred_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (pred_valid && pred_taken && pred_pc == $past(ent.tgt)));

    // R7
    pass_pred_chk: assert property (@(posedge clk) disable iff (rst)
        (verdict == V_PASS) |=> (pred_valid && !pred_taken
                                 && pred_pc == $past(iss_pc) + addr_t'(4)));

    // R8
    stall_nopred_chk: assert property (@(posedge clk) disable iff (rst)
        hint_stall |=> !pred_valid);

    // R9
    drop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (drop && !accept) |=> !ent.valid);

    // R4
    reject_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (hint_valid && !accept) |=> ($stable(ent.trig) && $stable(ent.tgt)));
endmodule

// File: tb/tb_branch_hint_buffer.sv
module tb_branch_hint_buffer;
    logic               clk = 1'b0;
    logic               rst;
    logic               hint_valid;
    logic [31:0]        hint_pc;
    logic [1:0]         hint_form;
    logic signed [10:0] hint_trig_off;
    logic signed [17:0] hint_tgt_imm;
    logic [31:0]        hint_reg_word;
    logic               iss_valid;
    logic [31:0]        iss_pc;
    logic               hint_stall;
    logic               pred_valid, pred_taken;
    logic [31:0]        pred_pc;
    logic               res_valid, res_taken;
    logic [31:0]        res_pc, res_target, res_pred_pc;
    logic               flush_valid;
    logic [31:0]        flush_pc;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    branch_hint_buffer dut (
        .clk(clk), .rst(rst),
        .hint_valid(hint_valid), .hint_pc(hint_pc), .hint_form(hint_form),
        .hint_trig_off(hint_trig_off), .hint_tgt_imm(hint_tgt_imm),
        .hint_reg_word(hint_reg_word),
        .iss_valid(iss_valid), .iss_pc(iss_pc), .hint_stall(hint_stall),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_pc(pred_pc),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_pred_pc(res_pred_pc),
        .flush_valid(flush_valid), .flush_pc(flush_pc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    function automatic logic [31:0] trig_of(input logic [31:0] pc, input int off);
        return pc + 32'(off * 4);
    endfunction

    function automatic logic [31:0] tgt_of(input int form, input logic [31:0] pc,
                                           input int imm, input logic [31:0] rw);
        if (form == 0) return rw & 32'hFFFF_FFFC;
        if (form == 1) return 32'(imm * 4);
        return pc + 32'(imm * 4);
    endfunction

    task automatic load_hint(input int form, input logic [31:0] pc, input int toff,
                             input int imm, input logic [31:0] rw);
        hint_valid    = 1'b1;
        hint_form     = 2'(form);
        hint_pc       = pc;
        hint_trig_off = 11'(toff);
        hint_tgt_imm  = 18'(imm);
        hint_reg_word = rw;
        tick();
        hint_valid = 1'b0;
    endtask

    // one issue with no stall expected, prediction checked the next cycle
    task automatic issue_one(input logic [31:0] pc, input bit exp_taken,
                             input logic [31:0] exp_pc, input string req);
        iss_valid = 1'b1;
        iss_pc    = pc;
        #1;
        chk(hint_stall == 1'b0, req, "no stall", 32'(hint_stall), 32'd0);
        tick();
        iss_valid = 1'b0;
        chk(pred_valid == 1'b1, req, "pred_valid", 32'(pred_valid), 32'd1);
        chk(pred_taken == exp_taken, req, "pred_taken", 32'(pred_taken), 32'(exp_taken));
        chk(pred_pc == exp_pc, req, "pred_pc", pred_pc, exp_pc);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        hint_valid = 1'b0; hint_pc = '0; hint_form = '0; hint_trig_off = '0;
        hint_tgt_imm = '0; hint_reg_word = '0;
        iss_valid = 1'b0; iss_pc = '0;
        res_valid = 1'b0; res_pc = '0; res_taken = 1'b0; res_target = '0; res_pred_pc = '0;
        idle(3);
        rst = 1'b0;

        // R1 reset state
        chk(pred_valid == 0 && flush_valid == 0 && hint_stall == 0, "R1", "outputs idle",
            {29'd0, pred_valid, flush_valid, hint_stall}, 32'd0);
        issue_one(32'h0000_0100, 1'b0, 32'h0000_0104, "R1");

        // R3 target forms over several immediates
        for (int f = 0; f < 3; f++) begin
            for (int k = 0; k < 6; k++) begin
                int imm;
                logic [31:0] hpc, rw;
                case (k)
                    0: imm = 0;
                    1: imm = 1;
                    2: imm = -1;
                    3: imm = 131071;
                    4: imm = -131072;
                    default: imm = 1000;
                endcase
                hpc = 32'h0000_4000 + 32'(f * 256 + k * 16);
                rw  = 32'hDEAD_BEE7 + 32'(k * 5);
                load_hint(f, hpc, 20, imm, rw);
                idle(16);
                issue_one(trig_of(hpc, 20), 1'b1, tgt_of(f, hpc, imm, rw), "R3");
            end
        end

        // R2 trigger offsets across the accepted range
        for (int off = -255; off <= 255; off += 17) begin
            logic [31:0] hpc;
            hpc = 32'h0001_0000;
            load_hint(1, hpc, off, 256, 32'd0);
            idle(16);
            issue_one(trig_of(hpc, off) - 32'd4, 1'b0, trig_of(hpc, off), "R2");
            issue_one(trig_of(hpc, off), 1'b1, 32'h0000_0400, "R2");
        end
        load_hint(2, 32'h0000_0010, -4, 3, 32'd0);   // trigger wraps below zero
        idle(16);
        issue_one(32'h0000_0000, 1'b1, 32'h0000_001C, "R2");

        // R4 out-of-range offsets and R3 reserved form keep the held entry
        load_hint(1, 32'h0002_0000, 8, 128, 32'd0);
        for (int k = 0; k < 5; k++) begin
            int off;
            int form;
            case (k)
                0: off = 256;
                1: off = -256;
                2: off = 1023;
                3: off = -1024;
                default: off = 12;
            endcase
            form = (k == 4) ? 3 : 1;
            load_hint(form, 32'h0003_0000, off, 900, 32'd0);
            idle(16);
            issue_one(trig_of(32'h0003_0000, off), 1'b0, trig_of(32'h0003_0000, off) + 32'd4,
                      (k == 4) ? "R3" : "R4");
            issue_one(trig_of(32'h0002_0000, 8), 1'b1, 32'h0000_0200, "R4");
        end

        // R5 replacement
        load_hint(1, 32'h0004_0000, 30, 64, 32'd0);
        load_hint(1, 32'h0005_0000, 40, 96, 32'd0);
        idle(16);
        issue_one(trig_of(32'h0004_0000, 30), 1'b0, trig_of(32'h0004_0000, 30) + 32'd4, "R5");
        issue_one(trig_of(32'h0005_0000, 40), 1'b1, 32'h0000_0180, "R5");

        // R6 R8 R9 R10 distance sweep
        for (int d = 1; d <= 20; d++) begin
            logic [31:0] hpc, tp, tg;
            hpc = 32'h0008_0000 + 32'(d * 256);
            tp  = trig_of(hpc, 50);
            tg  = 32'((12288 + d) * 4);
            load_hint(1, hpc, 50, 12288 + d, 32'd0);
            idle(d - 1);
            if (d <= 4) begin
                issue_one(tp, 1'b0, tp + 32'd4, "R9");
                idle(20);
                issue_one(tp, 1'b0, tp + 32'd4, "R9");
            end else if (d < 15) begin
                int stalls;
                int bad_pred;
                stalls   = 0;
                bad_pred = 0;
                iss_valid = 1'b1;
                iss_pc    = tp;
                #1;
                while (hint_stall && stalls < 40) begin
                    stalls++;
                    tick();
                    #1;
                    if (pred_valid) bad_pred++;
                end
                chk(stalls == 15 - d, "R8", "stall cycles", 32'(stalls), 32'(15 - d));
                chk(bad_pred == 0, "R8", "pred during stall", 32'(bad_pred), 32'd0);
                tick();
                iss_valid = 1'b0;
                chk(pred_valid && pred_taken, "R8", "fire after stall",
                    {30'd0, pred_valid, pred_taken}, 32'd3);
                chk(pred_pc == tg, "R8", "target after stall", pred_pc, tg);
            end else begin
                issue_one(tp, 1'b1, tg, "R6");
                idle(3);
                issue_one(tp, 1'b1, tg, "R10");
                issue_one(tp + 32'd8, 1'b0, tp + 32'd12, "R7");
                issue_one(tp, 1'b1, tg, "R10");
            end
        end

        // R11 flush decisions
        for (int c = 0; c < 4; c++) begin
            bit exp_f;
            logic [31:0] exp_pc;
            res_valid  = 1'b1;
            res_pc     = 32'h0000_0100;
            res_target = 32'h0000_0500;
            res_taken  = (c < 2);
            res_pred_pc = (c == 0) ? 32'h0000_0500 : (c == 1) ? 32'h0000_0104 :
                          (c == 2) ? 32'h0000_0104 : 32'h0000_0700;
            exp_f  = (c == 1) || (c == 3);
            exp_pc = res_taken ? 32'h0000_0500 : 32'h0000_0104;
            tick();
            res_valid = 1'b0;
            chk(flush_valid == exp_f, "R11", "flush_valid", 32'(flush_valid), 32'(exp_f));
            if (exp_f) chk(flush_pc == exp_pc, "R11", "flush_pc", flush_pc, exp_pc);
        end
        tick();
        chk(flush_valid == 1'b0, "R11", "flush idle", 32'(flush_valid), 32'd0);

        finish_run();
    end
endmodule